// File: doc/BRIEF.md
# Paged SerDes Control-Register Access Master

This block gives a simple request port access to the 16-bit internal registers of a SerDes PHY. The PHY only offers a small memory-mapped slave window. Every internal register is reached in two levels. A page value goes into a window-select location at byte offset 0x800. A second access then goes to a word inside the 512-entry page that was selected. The PHY's internal control path is itself indirect. Three internal registers, control at 0x80A0, target address at 0x80A1 and data at 0x80A2, carry each transaction to the PHY core.

One request names a device number, an internal target address, a direction and (for writes) a data word. The master first polls the busy bit of the control register. Successive polls are spaced by a parameterised gap. It then programs the address register, and the data register for writes, and issues the start command. A read polls again and fetches the data register. The caller sees a single-cycle done pulse, with read data or an error flag. The error flag is raised when busy stays set for a programmable number of consecutive polls.

Top module: `srm_master`

## Requirements
- R1: After reset `req_ready` is 1, `resp_done` and `resp_err` are 0, and no slave access is driven. While `req_ready` is 1 the slave port stays quiet.
- R2: Each access to a non-window offset comes in the cycle straight after a write to offset 0x800. The value written is `{dev[4:0], reg[15:9]}`, which is (dev<<7)|0x40 for the control registers. The page write is always followed at once by its data access.
- R3: The data access goes to byte offset `{reg[8:0],2'b00}`. That gives 0x280 for control, 0x284 for target address and 0x288 for data. No other offset is used.
- R4: Before programming anything, the master reads control at 0x280 until bit 0 (busy) reads 0. The address and data registers are never written while busy is set.
- R5: A read goes through these steps in order: poll, write the target address to 0x284, write 0x0001 to 0x280, poll again, read 0x288. The value read is returned on `resp_rdata` with the done pulse.
- R6: A write goes through these steps in order: poll, write the address to 0x284, write the data to 0x288, write 0x0003 to 0x280 (bit 1 is write, bit 0 is start). Done follows that last write, with no further poll.
- R7: Two consecutive busy polls with no other access between them are at least `GAP_CYCLES` clock cycles apart.
- R8: When max(`poll_limit`,1) consecutive polls in one polling stage all read busy, the request ends. `resp_done` and `resp_err` are both 1, and no address, data or command write follows.
- R9: A request is taken only while `req_ready` is 1. `req_ready` stays 0 until completion. `resp_done` is a single-cycle pulse.
- R10: `resp_err` is 0 on every completion that did not time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Master idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | PHY device number |
| req_addr | input | 16 | Internal target address |
| req_wdata | input | DW | Write data |
| poll_limit | input | LIMIT_W | Busy polls allowed before error (0 acts as 1) |
| resp_done | output | 1 | Completion pulse |
| resp_err | output | 1 | Busy timeout, valid with done |
| resp_rdata | output | DW | Read result, valid with done |
| phy_en | output | 1 | Slave access strobe |
| phy_we | output | 1 | Slave write enable |
| phy_addr | output | 12 | Slave byte offset |
| phy_wdata | output | DW | Slave write data |
| phy_rdata | input | DW | Slave read data, valid in the cycle of the access |

## Verification
A stale or wrong page register shows up on the very next slave access. The offset would appear without a page write in the cycle before it, or the page value would not match the device and upper address bits. A bad step sequencer shows up within one request. It would write the address register while the PHY reports busy, write a wrong command word, or return the sentinel the PHY model drives while still busy. A faulty poll counter shows up as a timeout after the wrong number of control reads, or polls closer together than the gap. All of these can be seen at the slave port before `resp_done` rises.

// File: rtl/srm_pkg.sv
package srm_pkg;
   localparam int PHY_AW = 12;
   localparam logic [15:0] CTL_REG = 16'h80A0;
   localparam logic [15:0] ADR_REG = 16'h80A1;
   localparam logic [15:0] DAT_REG = 16'h80A2;
   localparam logic [15:0] CMD_RD  = 16'h0001;
   localparam logic [15:0] CMD_WR  = 16'h0003;
   localparam logic [PHY_AW-1:0] WIN_OFS = 12'h800;

   typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_GAP} phase_t;
   typedef enum logic [2:0] {ST_POLL1, ST_ADDR, ST_WDATA, ST_CMD, ST_POLL2, ST_FETCH} step_t;

   function automatic logic [PHY_AW-1:0] page_of(input logic [4:0] dev, input logic [15:0] ra);
      return {dev, ra[15:9]};
   endfunction

   function automatic logic [PHY_AW-1:0] ofs_of(input logic [15:0] ra);
      return {1'b0, ra[8:0], 2'b00};
   endfunction
endpackage

// File: rtl/srm_window.sv
module srm_window
   import srm_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              we,
   input  logic [4:0]        dev,
   input  logic [15:0]       regad,
   input  logic [DW-1:0]     wdata,
   output logic              bus_en,
   output logic              bus_we,
   output logic [PHY_AW-1:0] bus_addr,
   output logic [DW-1:0]     bus_wdata,
   input  logic [DW-1:0]     bus_rdata,
   output logic              done,
   output logic [DW-1:0]     rdata
);
   typedef enum logic [1:0] {W_IDLE, W_PAGE, W_DATA} wst_t;
   wst_t            st;
   logic            we_q;
   logic [4:0]      dev_q;
   logic [15:0]     reg_q;
   logic [DW-1:0]   wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= W_IDLE;
         done  <= 1'b0;
         rdata <= '0;
         we_q  <= 1'b0;
         dev_q <= '0;
         reg_q <= '0;
         wd_q  <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            W_IDLE: if (go) begin
               we_q  <= we;
               dev_q <= dev;
               reg_q <= regad;
               wd_q  <= wdata;
               st    <= W_PAGE;
            end
            W_PAGE: st <= W_DATA;
            default: begin
               rdata <= bus_rdata;
               done  <= 1'b1;
               st    <= W_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      bus_en    = (st != W_IDLE);
      bus_we    = (st == W_PAGE) || we_q;
      bus_addr  = (st == W_PAGE) ? WIN_OFS : ofs_of(reg_q);
      bus_wdata = (st == W_PAGE) ? {{(DW-PHY_AW){1'b0}}, page_of(dev_q, reg_q)} : wd_q;
   end
endmodule

// File: rtl/srm_poll_timer.sv
module srm_poll_timer #(
   parameter int GAP_CYCLES = 1000,
   parameter int LIMIT_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               busy_seen,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               gap_start,
   output logic               gap_done,
   output logic               expired
);
   logic [LIMIT_W:0] busy_cnt;
   logic [LIMIT_W:0] eff_limit;

   always_comb begin
      eff_limit = (limit == '0) ? {{LIMIT_W{1'b0}}, 1'b1} : {1'b0, limit};
      expired   = busy_seen && ((busy_cnt + 1'b1) >= eff_limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) busy_cnt <= '0;
      else if (busy_seen) busy_cnt <= busy_cnt + 1'b1;
   end

   if (GAP_CYCLES == 0) begin : g_nogap
      assign gap_done = 1'b1;
   end else begin : g_gap
      localparam int GW = $clog2(GAP_CYCLES + 1);
      logic [GW-1:0] gcnt;
      logic          active;
      assign gap_done = active && (gcnt == GW'(1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            gcnt   <= '0;
            active <= 1'b0;
         end else if (gap_start) begin
            gcnt   <= GW'(GAP_CYCLES);
            active <= 1'b1;
         end else if (active) begin
            gcnt <= gcnt - 1'b1;
            if (gcnt == GW'(1)) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/srm_master.sv
module srm_master
   import srm_pkg::*;
#(
   parameter int DW         = 16,
   parameter int LIMIT_W    = 16,
   parameter int GAP_CYCLES = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [4:0]         req_dev,
   input  logic [15:0]        req_addr,
   input  logic [DW-1:0]      req_wdata,
   input  logic [LIMIT_W-1:0] poll_limit,
   output logic               resp_done,
   output logic               resp_err,
   output logic [DW-1:0]      resp_rdata,
   output logic               phy_en,
   output logic               phy_we,
   output logic [PHY_AW-1:0]  phy_addr,
   output logic [DW-1:0]      phy_wdata,
   input  logic [DW-1:0]      phy_rdata
);
   if (DW < 16) begin : g_bad_dw
      $error("srm_master: DW must be at least 16");
   end
   if (LIMIT_W < 1) begin : g_bad_lw
      $error("srm_master: LIMIT_W must be at least 1");
   end
   if (GAP_CYCLES < 0) begin : g_bad_gap
      $error("srm_master: GAP_CYCLES must not be negative");
   end

   phase_t          ph;
   step_t           step;
   logic            wr_q;
   logic [4:0]      dev_q;
   logic [15:0]     addr_q;
   logic [DW-1:0]   wd_q;

   logic            op_we;
   logic [15:0]     op_reg;
   logic [DW-1:0]   op_wdata;
   logic            win_done;
   logic [DW-1:0]   win_rdata;
   logic            is_poll, busy_seen, expired, gap_start, gap_done, clr;

   always_comb begin
      op_we    = 1'b0;
      op_reg   = CTL_REG;
      op_wdata = '0;
      case (step)
         ST_ADDR:  begin op_we = 1'b1; op_reg = ADR_REG; op_wdata = DW'(addr_q); end
         ST_WDATA: begin op_we = 1'b1; op_reg = DAT_REG; op_wdata = wd_q; end
         ST_CMD:   begin op_we = 1'b1; op_reg = CTL_REG; op_wdata = DW'(wr_q ? CMD_WR : CMD_RD); end
         ST_FETCH: begin op_reg = DAT_REG; end
         default:  ;
      endcase
      is_poll   = (step == ST_POLL1) || (step == ST_POLL2);
      busy_seen = (ph == PH_WAIT) && win_done && is_poll && win_rdata[0];
      gap_start = busy_seen && !expired;
      clr       = (ph == PH_IDLE) || ((ph == PH_WAIT) && win_done && (step == ST_CMD));
      req_ready = (ph == PH_IDLE);
   end

   srm_window #(.DW(DW)) win_i (
      .clk(clk), .rst_n(rst_n), .go(ph == PH_ISSUE), .we(op_we), .dev(dev_q),
      .regad(op_reg), .wdata(op_wdata), .bus_en(phy_en), .bus_we(phy_we),
      .bus_addr(phy_addr), .bus_wdata(phy_wdata), .bus_rdata(phy_rdata),
      .done(win_done), .rdata(win_rdata)
   );

   srm_poll_timer #(.GAP_CYCLES(GAP_CYCLES), .LIMIT_W(LIMIT_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .busy_seen(busy_seen), .limit(poll_limit),
      .gap_start(gap_start), .gap_done(gap_done), .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         step       <= ST_POLL1;
         wr_q       <= 1'b0;
         dev_q      <= '0;
         addr_q     <= '0;
         wd_q       <= '0;
         resp_done  <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_done <= 1'b0;
         resp_err  <= 1'b0;
         case (ph)
            PH_IDLE: if (req_valid) begin
               wr_q   <= req_write;
               dev_q  <= req_dev;
               addr_q <= req_addr;
               wd_q   <= req_wdata;
               step   <= ST_POLL1;
               ph     <= PH_ISSUE;
            end
            PH_ISSUE: ph <= PH_WAIT;
            PH_GAP: if (gap_done) ph <= PH_ISSUE;
            default: if (win_done) begin
               ph <= PH_ISSUE;
               case (step)
                  ST_POLL1, ST_POLL2: begin
                     if (win_rdata[0]) begin
                        if (expired) begin
                           resp_done <= 1'b1;
                           resp_err  <= 1'b1;
                           ph        <= PH_IDLE;
                        end else begin
                           ph <= PH_GAP;
                        end
                     end else begin
                        step <= (step == ST_POLL1) ? ST_ADDR : ST_FETCH;
                     end
                  end
                  ST_ADDR:  step <= wr_q ? ST_WDATA : ST_CMD;
                  ST_WDATA: step <= ST_CMD;
                  ST_CMD: begin
                     if (wr_q) begin
                        resp_done <= 1'b1;
                        ph        <= PH_IDLE;
                     end else begin
                        step <= ST_POLL2;
                     end
                  end
                  default: begin
                     resp_rdata <= win_rdata;
                     resp_done  <= 1'b1;
                     ph         <= PH_IDLE;
                  end
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/srm_master_chk.sv
module srm_master_chk
   import srm_pkg::*;
#(
   parameter int DW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              resp_done,
   input logic              resp_err,
   input logic              phy_en,
   input logic              phy_we,
   input logic [PHY_AW-1:0] phy_addr,
   input logic [DW-1:0]     phy_wdata
);
   logic page_wr, data_acc;
   assign page_wr  = phy_en && phy_we && (phy_addr == WIN_OFS);
   assign data_acc = phy_en && (phy_addr != WIN_OFS);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !phy_en);
   // R2
   page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |-> $past(page_wr));
   // R2
   page_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |=> data_acc);
   // R2
   page_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |-> (phy_wdata[6:0] == 7'h40));
   // R3
   data_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |-> (phy_addr == 12'h280 || phy_addr == 12'h284 || phy_addr == 12'h288));
   // R5
   cmd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && phy_we && phy_addr == 12'h280) |-> (phy_wdata == DW'(CMD_RD) || phy_wdata == DW'(CMD_WR)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);
   // R8
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> resp_done);
endmodule

bind srm_master srm_master_chk #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_done(resp_done),
   .resp_err(resp_err), .phy_en(phy_en), .phy_we(phy_we), .phy_addr(phy_addr),
   .phy_wdata(phy_wdata)
);

// File: tb/srm_master_tb.sv
module srm_master_tb_top;
   localparam int DW = 16;
   localparam int LW = 16;
   localparam int GAP = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid = 1'b0, req_write = 1'b0;
   logic          req_ready, resp_done, resp_err;
   logic [4:0]    req_dev = '0;
   logic [15:0]   req_addr = '0;
   logic [DW-1:0] req_wdata = '0, resp_rdata;
   logic [LW-1:0] poll_limit = 16'd100;
   logic          phy_en, phy_we;
   logic [11:0]   phy_addr;
   logic [DW-1:0] phy_wdata, phy_rdata;

   srm_master #(.DW(DW), .LIMIT_W(LW), .GAP_CYCLES(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr),
      .req_wdata(req_wdata), .poll_limit(poll_limit), .resp_done(resp_done),
      .resp_err(resp_err), .resp_rdata(resp_rdata), .phy_en(phy_en), .phy_we(phy_we),
      .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata)
   );

   // ---------------- PHY model ----------------
   logic          log_clr = 1'b0;
   logic          stuck = 1'b0;
   int            preset_busy = 0, busy_after_cmd = 0;
   logic [4:0]    dev_exp = '0;
   int            busy_left = 0, cyc = 0;
   logic [15:0]   m_page = '0, m_adr = '0, m_dat = '0, last_cmd = '0;
   logic [15:0]   mem [0:255];
   logic [2:0]    ev [0:15];
   int            ev_n = 0, page_bad = 0, ofs_bad = 0, wr_busy = 0;
   int            ctl_reads = 0, last_poll = -1, min_gap = 1000000;
   logic          busy;

   assign busy = stuck || (busy_left > 0);

   always_comb begin
      case (phy_addr)
         12'h280: phy_rdata = {15'b0, busy};
         12'h284: phy_rdata = m_adr;
         12'h288: phy_rdata = busy ? 16'hDEAD : m_dat;
         default: phy_rdata = '0;
      endcase
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (log_clr) begin
         ev_n <= 0; page_bad <= 0; ofs_bad <= 0; wr_busy <= 0;
         ctl_reads <= 0; last_poll <= -1; min_gap <= 1000000;
         busy_left <= preset_busy;
      end else if (phy_en) begin
         if (phy_addr == 12'h800 && phy_we) begin
            m_page <= phy_wdata;
         end else begin
            if (m_page != {4'b0, dev_exp, 7'h40}) page_bad <= page_bad + 1;
            if (phy_addr == 12'h280 && !phy_we) begin
               ctl_reads <= ctl_reads + 1;
               if (last_poll >= 0 && (cyc - last_poll) < min_gap) min_gap <= cyc - last_poll;
               last_poll <= cyc;
               if (busy_left > 0) busy_left <= busy_left - 1;
               if (ev_n < 16) ev[ev_n] <= 3'd1;
            end else begin
               last_poll <= -1;
               if (phy_we && busy) wr_busy <= wr_busy + 1;
               case ({phy_we, phy_addr})
                  {1'b1, 12'h284}: begin m_adr <= phy_wdata; if (ev_n < 16) ev[ev_n] <= 3'd2; end
                  {1'b1, 12'h288}: begin m_dat <= phy_wdata; if (ev_n < 16) ev[ev_n] <= 3'd3; end
                  {1'b1, 12'h280}: begin
                     last_cmd <= phy_wdata;
                     if (ev_n < 16) ev[ev_n] <= 3'd4;
                     if (phy_wdata[0]) begin
                        if (phy_wdata[1]) mem[m_adr[7:0]] <= m_dat;
                        else m_dat <= mem[m_adr[7:0]];
                        busy_left <= busy_after_cmd;
                     end
                  end
                  {1'b0, 12'h288}: begin if (ev_n < 16) ev[ev_n] <= 3'd5; end
                  default: ofs_bad <= ofs_bad + 1;
               endcase
            end
            ev_n <= ev_n + 1;
         end
      end
   end

   // ---------------- bookkeeping ----------------
   int tot = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      tot++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   logic [15:0] op_rd;
   logic        op_err;

   task automatic do_op(input bit wr, input logic [4:0] dev, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] lim);
      int n;
      @(negedge clk); log_clr = 1'b1; dev_exp = dev;
      @(negedge clk); log_clr = 1'b0;
      req_valid = 1'b1; req_write = wr; req_dev = dev; req_addr = a; req_wdata = d;
      poll_limit = lim;
      chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
      @(negedge clk); req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "ready low while busy", int'(req_ready), 0);
      n = 0;
      while (!resp_done && n < 5000) begin
         @(negedge clk); n++;
      end
      chk(n < 5000, "R9", "completion seen", n, 0);
      op_rd = resp_rdata; op_err = resp_err;
      @(negedge clk);
      chk(resp_done == 1'b0, "R9", "done single pulse", int'(resp_done), 0);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      chk(resp_done == 1'b0 && resp_err == 1'b0, "R1", "done/err after reset", int'({resp_done, resp_err}), 0);
      chk(phy_en == 1'b0, "R1", "slave quiet after reset", int'(phy_en), 0);
   endtask

   task automatic t_write_basic();
      preset_busy = 0; busy_after_cmd = 0;
      do_op(1'b1, 5'd3, 16'h0012, 16'hA5C3, 16'd100);
      chk(op_err == 1'b0, "R10", "no error on write", int'(op_err), 0);
      chk(ev_n == 4 && ev[0] == 3'd1 && ev[1] == 3'd2 && ev[2] == 3'd3 && ev[3] == 3'd4,
          "R6", "write step order", int'({ev[0], ev[1], ev[2], ev[3]}), 'o1234);
      chk(last_cmd == 16'h0003, "R6", "write command word", int'(last_cmd), 3);
      chk(page_bad == 0, "R2", "page value dev 3", page_bad, 0);
      chk(m_page == 16'h01C0, "R2", "page written dev 3", int'(m_page), 'h1C0);
      chk(ofs_bad == 0, "R3", "only control offsets", ofs_bad, 0);
   endtask

   task automatic t_read_basic();
      preset_busy = 0; busy_after_cmd = 0;
      do_op(1'b0, 5'd3, 16'h0012, 16'h0, 16'd100);
      chk(op_rd == 16'hA5C3, "R5", "read back data", int'(op_rd), 'hA5C3);
      chk(op_err == 1'b0, "R10", "no error on read", int'(op_err), 0);
      chk(ev_n == 5 && ev[0] == 3'd1 && ev[1] == 3'd2 && ev[2] == 3'd4 && ev[3] == 3'd1 && ev[4] == 3'd5,
          "R5", "read step order", int'({ev[0], ev[1], ev[2], ev[3], ev[4]}), 'o12415);
      chk(last_cmd == 16'h0001, "R5", "read command word", int'(last_cmd), 1);
      chk(ofs_bad == 0, "R3", "read offsets", ofs_bad, 0);
   endtask

   task automatic t_busy_poll();
      preset_busy = 2; busy_after_cmd = 3;
      do_op(1'b1, 5'h1F, 16'h0040, 16'h1234, 16'd100);
      chk(ev[0] == 3'd1 && ev[1] == 3'd1 && ev[2] == 3'd1 && ev[3] == 3'd2, "R4",
          "three polls before address", int'({ev[0], ev[1], ev[2], ev[3]}), 'o1112);
      chk(wr_busy == 0, "R4", "no write while busy", wr_busy, 0);
      chk(min_gap >= GAP, "R7", "poll spacing", min_gap, GAP);
      chk(page_bad == 0, "R2", "page value dev 31", page_bad, 0);
      preset_busy = 1; busy_after_cmd = 3;
      do_op(1'b0, 5'h1F, 16'h0040, 16'h0, 16'd100);
      chk(op_rd == 16'h1234, "R5", "read after busy wait", int'(op_rd), 'h1234);
      chk(ctl_reads == 2 + 4, "R4", "poll count with busy", ctl_reads, 6);
      chk(min_gap >= GAP, "R7", "poll spacing on read", min_gap, GAP);
   endtask

   task automatic t_timeout();
      stuck = 1'b1; preset_busy = 0; busy_after_cmd = 0;
      do_op(1'b1, 5'd5, 16'h0007, 16'h5555, 16'd3);
      chk(op_err == 1'b1, "R8", "error on stuck busy", int'(op_err), 1);
      chk(ctl_reads == 3 && ev_n == 3, "R8", "polls before abort limit 3", ctl_reads, 3);
      do_op(1'b0, 5'd5, 16'h0007, 16'h0, 16'd0);
      chk(op_err == 1'b1 && ctl_reads == 1 && ev_n == 1, "R8", "limit 0 acts as 1", ctl_reads, 1);
      stuck = 1'b0;
      do_op(1'b1, 5'h15, 16'h00AA, 16'hBEEF, 16'd3);
      chk(op_err == 1'b0, "R10", "recovery after timeout", int'(op_err), 0);
      chk(m_page == 16'h0AC0 && page_bad == 0, "R2", "page value dev 21", int'(m_page), 'hAC0);
      do_op(1'b0, 5'h15, 16'h00AA, 16'h0, 16'd3);
      chk(op_rd == 16'hBEEF, "R5", "read after recovery", int'(op_rd), 'hBEEF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_basic();
      t_read_basic();
      t_busy_poll();
      t_timeout();
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tot++; bad++;
      $display("FAIL watchdog act=%0d exp=0", 150000);
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
   end
endmodule